// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the address pairs for one memory-to-memory DMA channel. Software supplies, for each side (source and destination), a base address, an inner count, an outer count and two signed strides. After a start pulse the block walks both patterns in lock step and offers one source/destination address pair per transfer on a valid/ready stream; an external mover reads one word at the source address and writes it at the destination address. Because each side has its own two-level stride set, a single pass can cut a rectangular window such as a 16x16 macroblock out of a larger frame, or split packed RGB pixels into three separate colour planes.

Address stepping on each side: after every accepted transfer the inner counter counts down and the address moves by the inner stride. When the inner counter runs out, the address moves by the outer stride instead, the outer counter counts down and the inner counter reloads. Back-pressure rule: the stream holds `xfer_valid` and both addresses unchanged for as long as `xfer_ready` is low, and a transfer happens on each rising edge where both are high, so a ready that stays high yields one word per clock. Completion and configuration errors come out on two separate one-cycle interrupt pins.

Top module: `dma2d_agen`

## Requirements
- R1: After reset `busy`, `xfer_valid`, `irq_done` and `irq_err` are all low.
- R2: A `start` pulse seen while idle with a valid configuration makes `xfer_valid` and `busy` high in the next cycle, with `xfer_src` equal to the source base and `xfer_dst` equal to the destination base.
- R3: After an accepted transfer that is not the last of its inner run, each side's address advances by that side's inner stride, read as a signed STRIDE_W-bit value and added modulo 2^ADDR_W.
- R4: After an accepted transfer that ends an inner run, each side's address advances by that side's outer stride (signed), and a fresh inner run of the full inner count begins; the two sides wrap independently of each other.
- R5: While `xfer_valid` is high and `xfer_ready` is low, `xfer_valid`, `xfer_src` and `xfer_dst` hold their values into the next cycle; with `xfer_ready` held high a transfer is accepted on every clock.
- R6: Exactly inner count times outer count transfers are offered; `irq_done` is high for exactly the one cycle after the last transfer is accepted, and in that cycle `busy` and `xfer_valid` are already low.
- R7: A start whose source or destination inner or outer count is zero raises `irq_err` for exactly the next cycle and offers no transfer.
- R8: A start whose source total (inner times outer) differs from the destination total raises `irq_err` for exactly the next cycle and offers no transfer.
- R9: A `start` pulse or a configuration change while `busy` is high has no effect on the running pattern.
- R10: `irq_done` and `irq_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a pattern |
| src_base | input | ADDR_W | Source start address |
| src_icnt | input | CNT_W | Source words per inner run |
| src_ocnt | input | CNT_W | Source number of inner runs |
| src_istride | input | STRIDE_W | Source signed inner stride |
| src_ostride | input | STRIDE_W | Source signed outer stride |
| dst_base | input | ADDR_W | Destination start address |
| dst_icnt | input | CNT_W | Destination words per inner run |
| dst_ocnt | input | CNT_W | Destination number of inner runs |
| dst_istride | input | STRIDE_W | Destination signed inner stride |
| dst_ostride | input | STRIDE_W | Destination signed outer stride |
| xfer_valid | output | 1 | An address pair is offered |
| xfer_ready | input | 1 | The mover accepts the offered pair |
| xfer_src | output | ADDR_W | Address to read |
| xfer_dst | output | ADDR_W | Address to write |
| busy | output | 1 | A pattern is in progress |
| irq_done | output | 1 | One-cycle completion interrupt |
| irq_err | output | 1 | One-cycle configuration-error interrupt |

## Verification
The bench builds the block with ADDR_W=24, CNT_W=9 and STRIDE_W=12. The narrow address lets a pattern cross the top of the address space so that modulo wrap is observed, the 12-bit strides keep negative outer strides such as the plane-to-plane step of an RGB split within reach, and 9-bit counts still hold a full 16x16 macroblock. Patterns with different inner/outer shapes on each side but equal totals, randomised back-pressure, and starts issued mid-pattern are all compared against a bench model of the two address walks.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_RUN  = 1'b1
  } ch_state_e;
endpackage

// File: rtl/dma2d_walker.sv
// One side's two-level address walk: inner run of icnt words, ocnt runs.
module dma2d_walker #(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int STRIDE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                step,
  input  logic [ADDR_W-1:0]   base,
  input  logic [CNT_W-1:0]    icnt,
  input  logic [CNT_W-1:0]    ocnt,
  input  logic [STRIDE_W-1:0] istride,
  input  logic [STRIDE_W-1:0] ostride,
  output logic [ADDR_W-1:0]   addr,
  output logic                last
);
  localparam int EXT_W = ADDR_W - STRIDE_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0]    icur_q, ocur_q, ireload_q;
  logic [STRIDE_W-1:0] istr_q, ostr_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                inner_end;

  function automatic logic [ADDR_W-1:0] sext(input logic [STRIDE_W-1:0] s);
    return {{EXT_W{s[STRIDE_W-1]}}, s};
  endfunction

  assign inner_end = (icur_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      icur_q    <= '0;
      ocur_q    <= '0;
      ireload_q <= '0;
      istr_q    <= '0;
      ostr_q    <= '0;
    end else if (load) begin
      addr_q    <= base;
      icur_q    <= icnt;
      ocur_q    <= ocnt;
      ireload_q <= icnt;
      istr_q    <= istride;
      ostr_q    <= ostride;
    end else if (step) begin
      if (inner_end) begin
        addr_q <= addr_q + sext(ostr_q);
        icur_q <= ireload_q;
        ocur_q <= ocur_q - ONE;
      end else begin
        addr_q <= addr_q + sext(istr_q);
        icur_q <= icur_q - ONE;
      end
    end
  end

  assign addr = addr_q;
  assign last = inner_end && (ocur_q == ONE);
endmodule

// File: rtl/dma2d_cfgchk.sv
// Start-time configuration screen: zero counts or unequal totals.
module dma2d_cfgchk #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] src_icnt,
  input  logic [CNT_W-1:0] src_ocnt,
  input  logic [CNT_W-1:0] dst_icnt,
  input  logic [CNT_W-1:0] dst_ocnt,
  output logic             cfg_bad
);
  localparam int TOT_W = 2 * CNT_W;

  logic [TOT_W-1:0] src_total, dst_total;
  logic             any_zero;

  always_comb begin
    src_total = TOT_W'(src_icnt) * TOT_W'(src_ocnt);
    dst_total = TOT_W'(dst_icnt) * TOT_W'(dst_ocnt);
    any_zero  = (src_icnt == '0) || (src_ocnt == '0) ||
                (dst_icnt == '0) || (dst_ocnt == '0);
    cfg_bad   = any_zero || (src_total != dst_total);
  end
endmodule

// File: rtl/dma2d_agen.sv
module dma2d_agen
  import dma2d_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int STRIDE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   src_base,
  input  logic [CNT_W-1:0]    src_icnt,
  input  logic [CNT_W-1:0]    src_ocnt,
  input  logic [STRIDE_W-1:0] src_istride,
  input  logic [STRIDE_W-1:0] src_ostride,
  input  logic [ADDR_W-1:0]   dst_base,
  input  logic [CNT_W-1:0]    dst_icnt,
  input  logic [CNT_W-1:0]    dst_ocnt,
  input  logic [STRIDE_W-1:0] dst_istride,
  input  logic [STRIDE_W-1:0] dst_ostride,
  output logic                xfer_valid,
  input  logic                xfer_ready,
  output logic [ADDR_W-1:0]   xfer_src,
  output logic [ADDR_W-1:0]   xfer_dst,
  output logic                busy,
  output logic                irq_done,
  output logic                irq_err
);
  localparam int NSIDE = 2;

  ch_state_e state_q;
  logic      cfg_bad, load, fire;
  logic      done_q, err_q;

  logic [ADDR_W-1:0]   side_base [NSIDE];
  logic [CNT_W-1:0]    side_icnt [NSIDE];
  logic [CNT_W-1:0]    side_ocnt [NSIDE];
  logic [STRIDE_W-1:0] side_is   [NSIDE];
  logic [STRIDE_W-1:0] side_os   [NSIDE];
  logic [ADDR_W-1:0]   side_addr [NSIDE];
  logic [NSIDE-1:0]    side_last;

  assign side_base[0] = src_base;    assign side_base[1] = dst_base;
  assign side_icnt[0] = src_icnt;    assign side_icnt[1] = dst_icnt;
  assign side_ocnt[0] = src_ocnt;    assign side_ocnt[1] = dst_ocnt;
  assign side_is[0]   = src_istride; assign side_is[1]   = dst_istride;
  assign side_os[0]   = src_ostride; assign side_os[1]   = dst_ostride;

  dma2d_cfgchk #(.CNT_W(CNT_W)) u_chk (
    .src_icnt(src_icnt), .src_ocnt(src_ocnt),
    .dst_icnt(dst_icnt), .dst_ocnt(dst_ocnt),
    .cfg_bad (cfg_bad)
  );

  assign load = (state_q == CH_IDLE) && start && !cfg_bad;
  assign fire = xfer_valid && xfer_ready;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dma2d_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STRIDE_W(STRIDE_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .load(load), .step(fire),
      .base(side_base[s]), .icnt(side_icnt[s]), .ocnt(side_ocnt[s]),
      .istride(side_is[s]), .ostride(side_os[s]),
      .addr(side_addr[s]), .last(side_last[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        CH_IDLE: begin
          if (start) begin
            if (cfg_bad) err_q   <= 1'b1;
            else         state_q <= CH_RUN;
          end
        end
        CH_RUN: begin
          if (fire && side_last[0]) begin
            state_q <= CH_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= CH_IDLE;
      endcase
    end
  end

  assign busy       = (state_q == CH_RUN);
  assign xfer_valid = busy;
  assign xfer_src   = side_addr[0];
  assign xfer_dst   = side_addr[1];
  assign irq_done   = done_q;
  assign irq_err    = err_q;

  // R5: offered pair is held under back-pressure
  p_hold_under_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_src) && $stable(xfer_dst));

  // R8: equal totals mean both walks end on the same transfer
  p_sides_end_together_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (side_last[0] == side_last[1]));

  // R6: completion follows acceptance of the final pair
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> $past(fire && side_last[0]));

  // R6: channel is idle while completion is signalled
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> !busy && !xfer_valid);

  // R7: error only after an idle start, and with nothing offered
  p_err_no_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> !xfer_valid && $past(start && !busy));

  // R10: the two interrupts are exclusive
  p_irq_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_done, irq_err}));
endmodule

// File: tb/sim_dma2d_agen.sv
module sim_dma2d_agen;
  localparam int AW = 24;
  localparam int CW = 9;
  localparam int SW = 12;
  localparam logic [AW-1:0] AMASK = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] src_base = '0, dst_base = '0;
  logic [CW-1:0] src_icnt = '0, src_ocnt = '0, dst_icnt = '0, dst_ocnt = '0;
  logic [SW-1:0] src_istride = '0, src_ostride = '0, dst_istride = '0, dst_ostride = '0;
  logic          xfer_valid, xfer_ready = 1'b0;
  logic [AW-1:0] xfer_src, xfer_dst;
  logic          busy, irq_done, irq_err;

  always #2 clk = ~clk;

  dma2d_agen #(.ADDR_W(AW), .CNT_W(CW), .STRIDE_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_base(src_base), .src_icnt(src_icnt), .src_ocnt(src_ocnt),
    .src_istride(src_istride), .src_ostride(src_ostride),
    .dst_base(dst_base), .dst_icnt(dst_icnt), .dst_ocnt(dst_ocnt),
    .dst_istride(dst_istride), .dst_ostride(dst_ostride),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_src(xfer_src), .xfer_dst(xfer_dst),
    .busy(busy), .irq_done(irq_done), .irq_err(irq_err)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [AW-1:0] exp_src[$];
  logic [AW-1:0] exp_dst[$];
  bit  mon_on = 0;
  int  rmode = 0;
  bit  expect_done = 0;
  bit  seen_done = 0;
  bit  hold_pend = 0;
  logic [AW-1:0] hold_s, hold_d;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Bench model of one side's walk (R3, R4), pushed into the scoreboard
  task automatic gen_side(input bit to_dst, input int base, input int icnt,
                          input int ocnt, input int is, input int os);
    logic [AW-1:0] a = AW'(base);
    for (int o = 0; o < ocnt; o++) begin
      for (int i = 0; i < icnt; i++) begin
        if (to_dst) exp_dst.push_back(a); else exp_src.push_back(a);
        if (i == icnt - 1) a = (a + AW'(os)) & AMASK;
        else               a = (a + AW'(is)) & AMASK;
      end
    end
  endtask

  task automatic set_cfg(input int sb, input int si, input int so, input int sis, input int sos,
                         input int db, input int di, input int dd, input int dis, input int dos);
    src_base = AW'(sb); src_icnt = CW'(si); src_ocnt = CW'(so);
    src_istride = SW'(sis); src_ostride = SW'(sos);
    dst_base = AW'(db); dst_icnt = CW'(di); dst_ocnt = CW'(dd);
    dst_istride = SW'(dis); dst_ostride = SW'(dos);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_job(input string name, input int mode,
                         input int sb, input int si, input int so, input int sis, input int sos,
                         input int db, input int di, input int dd, input int dis, input int dos);
    set_cfg(sb, si, so, sis, sos, db, di, dd, dis, dos);
    gen_side(1'b0, sb, si, so, sis, sos);
    gen_side(1'b1, db, di, dd, dis, dos);
    rmode = mode;
    seen_done = 0;
    pulse_start();
    // R2: first pair is the two bases
    check(xfer_valid && busy, "R2", {name, " valid after start"}, xfer_valid, 1);
    check(xfer_src == AW'(sb), "R2", {name, " first src"}, xfer_src, sb);
    check(xfer_dst == AW'(db), "R2", {name, " first dst"}, xfer_dst, db);
    while (!seen_done) @(negedge clk);
    check(exp_src.size() == 0 && exp_dst.size() == 0, "R6", {name, " all pairs seen"},
          exp_src.size(), 0);
    @(negedge clk);
    check(!irq_done, "R6", {name, " done is one cycle"}, irq_done, 0);
  endtask

  task automatic err_job(input string req, input string name,
                         input int si, input int so, input int di, input int dd);
    set_cfg(100, si, so, 1, 1, 200, di, dd, 1, 1);
    pulse_start();
    check(irq_err, req, {name, " irq_err raised"}, irq_err, 1);
    check(!irq_done, "R10", {name, " done quiet on error"}, irq_done, 0);
    check(!xfer_valid && !busy, req, {name, " nothing offered"}, xfer_valid, 0);
    @(negedge clk);
    check(!irq_err, req, {name, " irq_err one cycle"}, irq_err, 0);
    repeat (3) begin
      @(negedge clk);
      check(!xfer_valid, req, {name, " still idle"}, xfer_valid, 0);
    end
  endtask

  // Monitor: sets ready for the coming edge, then scores what that edge accepts
  always @(negedge clk) begin
    if (mon_on) begin
      xfer_ready = (rmode == 0) ? 1'b1 : (($urandom % 3) != 0);
      if (hold_pend) begin
        check(xfer_valid && xfer_src == hold_s && xfer_dst == hold_d, "R5",
              "pair held under stall", xfer_src, hold_s);
        hold_pend = 0;
      end
      if (irq_done) begin
        check(expect_done, "R6", "done right after last accept", irq_done, expect_done);
        check(!busy && !xfer_valid, "R6", "idle during done", busy, 0);
        seen_done = 1;
      end else if (expect_done) begin
        check(1'b0, "R6", "done missing after last accept", irq_done, 1);
        seen_done = 1;
      end
      expect_done = 0;
      if (xfer_valid && xfer_ready) begin
        if (exp_src.size() == 0) begin
          check(1'b0, "R6", "extra transfer", xfer_src, 0);
        end else begin
          logic [AW-1:0] es, ed;
          es = exp_src.pop_front();
          ed = exp_dst.pop_front();
          check(xfer_src == es, "R3/R4", "src address", xfer_src, es);
          check(xfer_dst == ed, "R3/R4", "dst address", xfer_dst, ed);
          if (exp_src.size() == 0) expect_done = 1;
        end
      end else if (xfer_valid) begin
        hold_pend = 1;
        hold_s = xfer_src;
        hold_d = xfer_dst;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WDOG", "run timed out", 0, 1);
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !xfer_valid && !irq_done && !irq_err, "R1", "outputs under reset",
          {busy, xfer_valid, irq_done, irq_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !xfer_valid && !irq_done && !irq_err, "R1", "outputs after reset",
          {busy, xfer_valid, irq_done, irq_err}, 0);
    mon_on = 1;

    // Plain contiguous copy, ready held high: one word per clock (R5)
    run_job("linear", 0, 16, 4, 3, 1, 1, 512, 4, 3, 1, 1);
    // R4: 16x16 window from a 64-wide frame, random back-pressure
    run_job("macroblock", 1, 64*5+8, 16, 16, 1, 49, 4096, 16, 16, 1, 1);
    // R4: RGB split, 8 pixels, negative outer stride on source, plane gap on destination
    run_job("rgb_split", 1, 1000, 8, 3, 3, 4-3*8, 2000, 8, 3, 1, 9);
    // R3/R4: different shapes on each side, negative inner stride, address wrap
    run_job("reshape_wrap", 1, 'hFFFFFC, 6, 2, 1, 1, 300, 3, 4, -1, 7);
    // Single word
    run_job("single", 0, 7, 1, 1, 5, 5, 9, 1, 1, 5, 5);

    // R7 / R8: configuration errors
    err_job("R7", "zero src inner", 0, 4, 4, 1);
    err_job("R7", "zero dst outer", 4, 2, 8, 0);
    err_job("R8", "total mismatch", 4, 4, 3, 5);

    // R9: start and config change while busy are ignored
    set_cfg(40, 5, 4, 2, 3, 800, 10, 2, 1, 1);
    gen_side(1'b0, 40, 5, 4, 2, 3);
    gen_side(1'b1, 800, 10, 2, 1, 1);
    rmode = 1;
    seen_done = 0;
    pulse_start();
    repeat (4) @(negedge clk);
    set_cfg(5000, 2, 2, 9, 9, 6000, 2, 2, 9, 9);
    pulse_start();
    check(busy, "R9", "still busy after second start", busy, 1);
    while (!seen_done) @(negedge clk);
    check(exp_src.size() == 0, "R9", "first pattern completed unchanged", exp_src.size(), 0);
    repeat (3) @(negedge clk);
    check(!xfer_valid && !busy, "R9", "no second pattern launched", xfer_valid, 0);

    mon_on = 0;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule